// File: doc/BRIEF.md
# Cycle-Steal Display Memory Arbiter

This block puts one single-port display memory between two users: a host processor and the display refresh fetch path. Clock cycles alternate between two slots. The first slot after reset belongs to the host, and the slot after it belongs to a refresh fetch. The host sees an asynchronous-style strobe interface: an active-low chip select, a read strobe, low and high write strobes, a bus-high-enable input, a byte address and a 16-bit data bus. When the host must wait for its slot, an active-low wait output tells it so.

Slot sharing, which is called cycle stealing here, is only used while the display is scanning the visible part of a line. The timing generator reports this on the display-active input. While the line is in its blanking interval, no refresh fetch is needed. During blanking the host owns the memory port on every cycle and never waits. A status output shows whether cycle stealing is in force.

The byte capacity is a parameter. The full configuration is 19200 bytes, addressed from 0x0000 to 0x4AFF. The default is kept smaller so that elaboration stays light.

Top module: `vramStealArb`

## Requirements
- R1: Slots alternate on every clock edge, and the first edge after reset is a host slot. While cycle stealing is active, a fetch is only taken on a fetch-slot edge. A fetch request raised just before a fetch-slot edge therefore returns in 1 edge, and one raised just before a host-slot edge returns in 2 edges.
- R2: While cycle stealing is active, waitN goes low as soon as three things are true together: csN is low, some strobe (rdN, lwrN, or hwrN in split-strobe mode) is low, and the address is in range. No clock edge is needed for this.
- R3: A waiting host access completes on the first host-slot edge. A write commits on that edge, and waitN returns high right after it. For a read, dOut holds the read data while the strobes stay asserted. The wait never spans more than 2 edges.
- R4: While cycle stealing is inactive, waitN stays high. Read data appears on dOut without any clock edge, and a write commits on the next edge.
- R5: stealOn follows dispActive with one clock of delay. Reset clears it to 0.
- R6: A fetch is taken only while stealOn is 1. fetchValid pulses for one cycle after the fetch-slot edge that served the request. While fetchValid is high, fetchData holds the 16-bit word at fetchAddr, with the even byte in bits 7:0.
- R7: In byte mode (hostWide=0), the write strobe is lwrN and the data is dIn[7:0]. Byte address a is stored in word a>>1, in the low lane when a[0]=0 and the high lane when a[0]=1. A read returns that byte in dOut[7:0], with dOut[15:8]=0.
- R8: In 16-bit mode with laneSplit=0, the write strobe is lwrN. The low lane is written when addr[0]=0, from dIn[7:0]. The high lane is written when bheN=0, from dIn[15:8]. A read returns the whole word at addr>>1.
- R9: In 16-bit mode with laneSplit=1, lwrN writes the low lane from dIn[7:0] and hwrN writes the high lane from dIn[15:8]. Both write the word at addr>>1.
- R10: An access is out of range when its byte address (with bit 0 cleared in 16-bit mode) is at or above MEM_BYTES. Such a write changes no stored byte, such a read returns 0, and neither one pulls waitN low.
- R11: During and right after reset, waitN=1, stealOn=0 and fetchValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWide | input | 1 | 1 = 16-bit host, 0 = byte host |
| laneSplit | input | 1 | 16-bit lane choice: 1 = separate strobes, 0 = addr[0]/bheN |
| csN | input | 1 | Memory chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| lwrN | input | 1 | Low write strobe, active low |
| hwrN | input | 1 | High write strobe, active low |
| bheN | input | 1 | Bus high enable, active low |
| addr | input | ADDR_W | Host byte address |
| dIn | input | 16 | Host write data |
| dOut | output | 16 | Host read data |
| waitN | output | 1 | Host wait, active low |
| stealOn | output | 1 | Cycle stealing in force |
| dispActive | input | 1 | Visible part of a line from timing generator |
| fetchReq | input | 1 | Refresh fetch request, held until fetchValid |
| fetchAddr | input | WADDR_W | Refresh word address |
| fetchValid | output | 1 | Fetch data valid pulse |
| fetchData | output | 16 | Fetched word |

## Verification
A wrong slot phase shows up in the first fetch or the first waiting access after reset. The wait length, or the fetch latency, comes out one edge off from what the parity predicts. A served flag that is stuck or cleared too early shows up at once as a wait that lasts for ever, or as a second write and stale read data in the next access. A lane or range decode error corrupts bytes the bench wrote earlier. It becomes visible in the closing whole-memory readback.

// File: rtl/stealPkg.sv
package stealPkg;

  typedef enum logic {
    SLOT_HOST  = 1'b0,
    SLOT_FETCH = 1'b1
  } slotT;

  // control-to-datapath strobes
  typedef struct packed {
    logic portHost;   // memory port addressed by host this cycle
    logic wrLo;       // commit low byte lane
    logic wrHi;       // commit high byte lane
    logic hostCap;    // capture host read data into latch
    logic useLatch;   // present latched data on dOut
    logic fetchCap;   // capture fetch word
  } strobeT;

endpackage

// File: rtl/stealCtrl.sv
module stealCtrl
  import stealPkg::*;
#(
  parameter int MEM_BYTES = 4800,
  parameter int ADDR_W    = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWide,
  input  logic              laneSplit,
  input  logic              csN,
  input  logic              rdN,
  input  logic              lwrN,
  input  logic              hwrN,
  input  logic              bheN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dispActive,
  input  logic              fetchReq,
  output strobeT            strb,
  output logic              inRange,
  output logic              waitN,
  output logic              stealOn,
  output logic              fetchValid
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

  slotT        slot;
  logic        served;
  logic        splitMode;
  logic        wantWr;
  logic        req;
  logic        live;
  logic        hostGo;
  logic        fetchGo;
  logic        laneLo;
  logic        laneHi;
  logic [ADDR_W-1:0] byteAddr;

  assign splitMode = hostWide & laneSplit;
  assign wantWr    = ~lwrN | (splitMode & ~hwrN);
  assign req       = ~csN & (wantWr | ~rdN);
  assign byteAddr  = hostWide ? {addr[ADDR_W-1:1], 1'b0} : addr;
  assign inRange   = {1'b0, byteAddr} < LIMIT;
  assign live      = req & inRange;

  always_comb begin
    if (stealOn) hostGo = live & ~served & (slot == SLOT_HOST);
    else         hostGo = live;
  end

  assign fetchGo = stealOn & (slot == SLOT_FETCH) & fetchReq;

  // byte lane selection for writes
  always_comb begin
    if (!hostWide) begin
      laneLo = ~lwrN & ~addr[0];
      laneHi = ~lwrN &  addr[0];
    end else if (laneSplit) begin
      laneLo = ~lwrN;
      laneHi = ~hwrN;
    end else begin
      laneLo = ~lwrN & ~addr[0];
      laneHi = ~lwrN & ~bheN;
    end
  end

  always_comb begin
    strb.portHost = ~stealOn | (slot == SLOT_HOST);
    strb.wrLo     = hostGo & laneLo;
    strb.wrHi     = hostGo & laneHi;
    strb.hostCap  = hostGo & stealOn;
    strb.useLatch = stealOn;
    strb.fetchCap = fetchGo;
  end

  assign waitN = ~(live & stealOn & ~served);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot       <= SLOT_HOST;
      stealOn    <= 1'b0;
      served     <= 1'b0;
      fetchValid <= 1'b0;
    end else begin
      slot       <= (slot == SLOT_HOST) ? SLOT_FETCH : SLOT_HOST;
      stealOn    <= dispActive;
      served     <= req ? (served | (stealOn & hostGo)) : 1'b0;
      fetchValid <= fetchGo;
    end
  end

endmodule

// File: rtl/stealData.sv
module stealData
  import stealPkg::*;
#(
  parameter int MEM_BYTES = 4800,
  parameter int ADDR_W    = 15,
  parameter int WADDR_W   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic               inRange,
  input  logic               hostWide,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [15:0]        dIn,
  input  logic [WADDR_W-1:0] fetchAddr,
  output logic [15:0]        dOut,
  output logic [15:0]        fetchData
);

  localparam int              WORDS   = MEM_BYTES / 2;
  localparam logic [WADDR_W:0] WORDS_L = (WADDR_W+1)'(WORDS);

  logic [WADDR_W-1:0] hostIdx;
  logic [WADDR_W-1:0] portIdx;
  logic               idxOk;
  logic [7:0]         hiByte;
  logic [7:0]         laneRd [2];
  logic [15:0]        portWord;
  logic [15:0]        hostFmt;
  logic [15:0]        hostLatch;

  assign hostIdx = WADDR_W'(addr[ADDR_W-1:1]);
  assign portIdx = strb.portHost ? hostIdx : fetchAddr;
  assign idxOk   = {1'b0, portIdx} < WORDS_L;
  assign hiByte  = hostWide ? dIn[15:8] : dIn[7:0];

  for (genvar ln = 0; ln < 2; ln++) begin : gLane
    logic [7:0] bank [WORDS];
    logic       wrEn;
    logic [7:0] wrByte;

    assign wrEn   = (ln == 0) ? strb.wrLo : strb.wrHi;
    assign wrByte = (ln == 0) ? dIn[7:0]  : hiByte;

    always_ff @(posedge clk) begin
      if (wrEn) bank[hostIdx] <= wrByte;
    end

    assign laneRd[ln] = idxOk ? bank[portIdx] : 8'h00;
  end

  assign portWord = {laneRd[1], laneRd[0]};

  always_comb begin
    if (hostWide)     hostFmt = portWord;
    else if (addr[0]) hostFmt = {8'h00, portWord[15:8]};
    else              hostFmt = {8'h00, portWord[7:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostLatch <= '0;
      fetchData <= '0;
    end else begin
      if (strb.hostCap)  hostLatch <= hostFmt;
      if (strb.fetchCap) fetchData <= portWord;
    end
  end

  always_comb begin
    if (!inRange)           dOut = 16'h0000;
    else if (strb.useLatch) dOut = hostLatch;
    else                    dOut = hostFmt;
  end

endmodule

// File: rtl/vramStealArb.sv
module vramStealArb
  import stealPkg::*;
#(
  parameter int MEM_BYTES = 4800,
  parameter int ADDR_W    = 15,
  parameter int WADDR_W   = $clog2(MEM_BYTES / 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWide,
  input  logic               laneSplit,
  input  logic               csN,
  input  logic               rdN,
  input  logic               lwrN,
  input  logic               hwrN,
  input  logic               bheN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [15:0]        dIn,
  output logic [15:0]        dOut,
  output logic               waitN,
  output logic               stealOn,
  input  logic               dispActive,
  input  logic               fetchReq,
  input  logic [WADDR_W-1:0] fetchAddr,
  output logic               fetchValid,
  output logic [15:0]        fetchData
);

  strobeT strb;
  logic   inRange;

  stealCtrl #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hostWide(hostWide), .laneSplit(laneSplit),
    .csN(csN), .rdN(rdN), .lwrN(lwrN), .hwrN(hwrN), .bheN(bheN),
    .addr(addr), .dispActive(dispActive), .fetchReq(fetchReq),
    .strb(strb), .inRange(inRange), .waitN(waitN), .stealOn(stealOn),
    .fetchValid(fetchValid)
  );

  stealData #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W), .WADDR_W(WADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .inRange(inRange),
    .hostWide(hostWide), .addr(addr), .dIn(dIn), .fetchAddr(fetchAddr),
    .dOut(dOut), .fetchData(fetchData)
  );

endmodule

// File: rtl/stealChecker.sv
module stealChecker #(
  parameter int MEM_BYTES = 4800,
  parameter int ADDR_W    = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              hostWide,
  input logic [ADDR_W-1:0] addr,
  input logic              waitN,
  input logic              stealOn,
  input logic              dispActive,
  input logic              fetchValid
);

  logic [1:0] waitRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      waitRun <= 2'd0;
    else if (waitN) waitRun <= 2'd0;
    else if (waitRun != 2'd3) waitRun <= waitRun + 2'd1;
  end

  AST_IDLE_NO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    !stealOn |-> waitN);                                               // R4
  AST_STEAL_RISE: assert property (@(posedge clk) disable iff (!rstN)
    dispActive |=> stealOn);                                           // R5
  AST_STEAL_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !dispActive |=> !stealOn);                                         // R5
  AST_FETCH_ALTERNATE: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> !fetchValid);                                       // R1
  AST_FETCH_NEEDS_STEAL: assert property (@(posedge clk) disable iff (!rstN)
    !stealOn |=> !fetchValid);                                         // R6
  AST_RANGE_NO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !hostWide && ({1'b0, addr} >= (ADDR_W+1)'(MEM_BYTES))) |-> waitN); // R10
  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    !waitN |-> (waitRun < 2'd2));                                      // R3

endmodule

bind vramStealArb stealChecker #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .hostWide(hostWide), .addr(addr),
  .waitN(waitN), .stealOn(stealOn), .dispActive(dispActive),
  .fetchValid(fetchValid)
);

// File: tb/sim_vramStealArb.sv
`timescale 1ns/1ps
module sim_vramStealArb;

  localparam int MB  = 96;
  localparam int AW  = 8;
  localparam int WAW = $clog2(MB / 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWide = 1'b0, laneSplit = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, lwrN = 1'b1, hwrN = 1'b1, bheN = 1'b1;
  logic [AW-1:0]  addr = '0;
  logic [15:0]    dIn = '0;
  logic [15:0]    dOut;
  logic           waitN, stealOn;
  logic           dispActive = 1'b0;
  logic           fetchReq = 1'b0;
  logic [WAW-1:0] fetchAddr = '0;
  logic           fetchValid;
  logic [15:0]    fetchData;

  int  nChk = 0;
  int  nFail = 0;
  bit  bs;
  logic [7:0] mdl [MB];

  always #5 clk = ~clk;

  // slot parity as the requirement defines it: host slot on first edge after reset
  always @(posedge clk) begin
    if (!rstN) bs <= 1'b0;
    else       bs <= ~bs;
  end

  vramStealArb #(.MEM_BYTES(MB), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .hostWide(hostWide), .laneSplit(laneSplit),
    .csN(csN), .rdN(rdN), .lwrN(lwrN), .hwrN(hwrN), .bheN(bheN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .waitN(waitN), .stealOn(stealOn),
    .dispActive(dispActive), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .fetchData(fetchData)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int a, input logic [15:0] d,
                        input bit wide, input bit split, input bit bhe,
                        input bit useLo, input bit useHi,
                        output logic [15:0] rv, output bit sawLow,
                        output int edges, output bit startSlot);
    @(negedge clk);
    startSlot = bs;
    addr = AW'(a); dIn = d; hostWide = wide; laneSplit = split; bheN = bhe;
    csN = 1'b0;
    if (wr) begin
      if (wide && split) begin lwrN = !useLo; hwrN = !useHi; end
      else lwrN = 1'b0;
    end else rdN = 1'b0;
    #1;
    sawLow = !waitN;
    edges = 0;
    while (!waitN && edges < 8) begin
      @(posedge clk); edges++; @(negedge clk); #1;
    end
    if (!sawLow && wr) begin
      @(posedge clk); @(negedge clk); #1;
    end
    rv = dOut;
    csN = 1'b1; rdN = 1'b1; lwrN = 1'b1; hwrN = 1'b1; bheN = 1'b1;
  endtask

  task automatic doFetch(input int w);
    int e;
    int expE;
    @(negedge clk);
    fetchAddr = WAW'(w); fetchReq = 1'b1;
    expE = bs ? 1 : 2;
    e = 0;
    do begin
      @(posedge clk); e++; @(negedge clk); #1;
    end while (!fetchValid && e < 8);
    chk(e == expE, "R1 fetch latency", e, expE);
    chk(fetchData == {mdl[2*w+1], mdl[2*w]}, "R6 fetch data", fetchData, {mdl[2*w+1], mdl[2*w]});
    fetchReq = 1'b0;
  endtask

  task automatic readAllWords(input string tag);
    logic [15:0] rv; bit low; int e; bit ss;
    for (int w = 0; w < MB / 2; w++) begin
      access(1'b0, 2*w, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
      chk(rv == {mdl[2*w+1], mdl[2*w]}, tag, rv, {mdl[2*w+1], mdl[2*w]});
    end
  endtask

  initial begin
    #(200000 * 10);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic [15:0] rv; bit low; int e; bit ss; bit seen;

    #1;
    chk(waitN == 1'b1 && stealOn == 1'b0 && fetchValid == 1'b0, "R11 in reset",
        {waitN, stealOn, fetchValid}, 3'b100);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk(waitN == 1'b1 && stealOn == 1'b0 && fetchValid == 1'b0, "R11 after reset",
        {waitN, stealOn, fetchValid}, 3'b100);

    // blanking: byte-mode fill and combinational readback
    for (int a = 0; a < MB; a++) begin
      access(1'b1, a, {8'h00, pat(a)}, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
      mdl[a] = pat(a);
      chk(!low, "R4 no wait on idle write", low, 0);
    end
    for (int a = 0; a < MB; a++) begin
      access(1'b0, a, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
      chk(!low && rv == {8'h00, mdl[a]}, "R7 R4 byte read", {low, rv}, {8'h00, mdl[a]});
    end

    // enter display
    @(negedge clk); dispActive = 1'b1;
    @(negedge clk); #1;
    chk(stealOn == 1'b1, "R5 stealOn rise", stealOn, 1);

    // word reads with wait, latency by slot parity
    for (int w = 0; w < MB / 2; w++) begin
      access(1'b0, 2*w, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
      chk(low, "R2 wait asserted", low, 1);
      chk(e == (ss ? 2 : 1), "R3 wait length", e, ss ? 2 : 1);
      chk(rv == {mdl[2*w+1], mdl[2*w]}, "R3 R8 word read", rv, {mdl[2*w+1], mdl[2*w]});
    end

    for (int w = 0; w < MB / 2; w++) doFetch(w);

    // address/BHE lane writes during display
    access(1'b1, 6, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, rv, low, e, ss);
    mdl[6] = 8'h34; mdl[7] = 8'h12;
    chk(low && e == (ss ? 2 : 1), "R3 write wait", e, ss ? 2 : 1);
    access(1'b1, 8, 16'hAB56, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
    mdl[8] = 8'h56;
    access(1'b1, 11, 16'h9AC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, rv, low, e, ss);
    mdl[11] = 8'h9A;
    access(1'b0, 8, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
    chk(rv == {mdl[9], 8'h56}, "R8 low lane only", rv, {mdl[9], 8'h56});
    access(1'b0, 10, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
    chk(rv == {8'h9A, mdl[10]}, "R8 high lane only", rv, {8'h9A, mdl[10]});

    // split strobe writes
    access(1'b1, 12, 16'h7788, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, rv, low, e, ss);
    mdl[12] = 8'h88;
    access(1'b1, 14, 16'h99AA, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, rv, low, e, ss);
    mdl[15] = 8'h99;
    access(1'b1, 17, 16'hC0DE, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, rv, low, e, ss);
    mdl[16] = 8'hDE; mdl[17] = 8'hC0;
    access(1'b0, 12, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
    chk(rv == {mdl[13], 8'h88}, "R9 low strobe", rv, {mdl[13], 8'h88});
    access(1'b0, 14, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
    chk(rv == {8'h99, mdl[14]}, "R9 high strobe", rv, {8'h99, mdl[14]});
    access(1'b0, 16, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
    chk(rv == 16'hC0DE, "R9 both strobes", rv, 16'hC0DE);

    // byte write under steal
    access(1'b1, 21, 16'h005A, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
    mdl[21] = 8'h5A;
    access(1'b0, 21, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
    chk(low && rv == 16'h005A, "R7 byte read under steal", rv, 16'h005A);

    // out of range
    foreach (mdl[i]) if (i < 0) mdl[i] = 8'h00;
    for (int k = 0; k < 5; k++) begin
      int a;
      a = (k == 0) ? 96 : (k == 1) ? 97 : (k == 2) ? 128 : (k == 3) ? 160 : 255;
      access(1'b1, a, 16'hEEEE, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
      chk(!low, "R10 no wait on range write", low, 0);
      access(1'b0, a, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
      chk(!low && rv == 16'h0, "R10 range read zero", {low, rv}, 0);
    end
    access(1'b1, 96, 16'hEEEE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, rv, low, e, ss);
    chk(!low, "R10 no wait on word range write", low, 0);

    readAllWords("R10 R3 final contents");

    // leave display: fetches are refused
    @(negedge clk); dispActive = 1'b0;
    @(negedge clk); #1;
    chk(stealOn == 1'b0, "R5 stealOn fall", stealOn, 0);
    @(negedge clk); fetchAddr = '0; fetchReq = 1'b1;
    seen = 1'b0;
    repeat (6) begin @(negedge clk); #1; if (fetchValid) seen = 1'b1; end
    fetchReq = 1'b0;
    chk(!seen, "R6 no fetch while idle", seen, 0);

    access(1'b0, 7, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, rv, low, e, ss);
    chk(!low && rv == {8'h00, mdl[7]}, "R4 idle read after display", rv, {8'h00, mdl[7]});

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule